// File: doc/BRIEF.md
# Hierarchical Depth Early-Cull Unit

This unit sits between the rasterizer and shader dispatch. Each arriving fragment carries a pixel position, an interpolated depth and a flag that says whether its shader may rewrite depth. The unit looks up a small on-chip table that holds one conservative value per 8x8 screen tile: the farthest depth still present anywhere in that tile. A fragment that is certainly hidden is discarded before any shading work is spent on it. Every other fragment is forwarded unchanged.

The depth function is less-than, with 16-bit depths where all ones is the far plane. A fragment with depth greater than or equal to its tile's stored value could never pass the final full-resolution test, so dropping it is safe. The full-resolution test downstream reports a tile's new farthest depth through an update port whenever it has covered that whole tile. The table then tightens, because a stored value only ever moves nearer. A clear input resets every tile to the far plane.

Top module: `hz_early_cull`

## Requirements
- R1: After reset every tile holds the far plane (16'hFFFF), `out_valid` is 0 and `in_ready` is 1, so a fragment of depth 16'hFFFE anywhere is forwarded.
- R2: A forwarded fragment appears on the output on the clock edge that accepts it, with x, y, depth and flag unchanged.
- R3: A fragment with the flag at 0 and depth greater than or equal to its tile's stored value is consumed (input handshake completes) and produces no output beat.
- R4: A fragment with the flag at 0 and depth strictly less than its tile's stored value is forwarded.
- R5: A fragment with the flag at 1 is always forwarded, whatever its depth.
- R6: The tile of a fragment is column x>>3 and row y>>3. An update to one tile has no effect on fragments in any other tile.
- R7: An update with `upd_full` at 0 is ignored.
- R8: An update whose value is not strictly nearer (smaller) than the stored value is ignored.
- R9: A clear sets every tile to the far plane on the next edge and takes priority over an update in the same cycle.
- R10: While `out_valid` is 1 and `out_ready` is 0, the output beat is held stable and `in_ready` is 0.
- R11: An update accepted on one edge is applied to fragments accepted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Set every tile to the far plane |
| in_valid | input | 1 | Fragment offered |
| in_ready | output | 1 | Fragment can be accepted |
| in_x | input | XW (7) | Pixel column |
| in_y | input | YW (7) | Pixel row |
| in_z | input | 16 | Interpolated depth |
| in_zmod | input | 1 | Shader may modify depth |
| out_valid | output | 1 | Fragment forwarded |
| out_ready | input | 1 | Downstream accepts |
| out_x | output | XW (7) | Pixel column |
| out_y | output | YW (7) | Pixel row |
| out_z | output | 16 | Depth |
| out_zmod | output | 1 | Depth-modify flag |
| upd_valid | input | 1 | Tile report present |
| upd_full | input | 1 | Reported tile fully covered |
| upd_tx | input | TXW (4) | Tile column |
| upd_ty | input | TYW (4) | Tile row |
| upd_zmax | input | 16 | New farthest depth of the tile |

## Verification
A tile entry that is too near shows up as a missing output beat for a fragment that should have survived. A tile entry that is too far shows up as an extra beat. Either one is visible on the edge that accepts the next fragment sent to that tile. A wrong tile index corrupts a neighbour, so probes on both sides of tile borders expose it. A wrong clear or update priority shows up one edge later in the kill decision of a probe fragment.

// File: rtl/hz_pkg.sv
package hz_pkg;
  parameter int unsigned HZ_ZW = 16;
  typedef logic [HZ_ZW-1:0] hz_depth_t;
  localparam hz_depth_t HZ_FAR = '1;

  // hidden under a less-than depth function, unless shader owns depth
  function automatic logic hz_is_hidden(hz_depth_t z, hz_depth_t zmax, logic zmod);
    return !zmod && (z >= zmax);
  endfunction

  // a report may only pull the tile bound nearer
  function automatic logic hz_tighter(hz_depth_t cand, hz_depth_t cur);
    return cand < cur;
  endfunction
endpackage

// File: rtl/hz_tile_store.sv
module hz_tile_store
  import hz_pkg::*;
#(
  parameter int unsigned TXW = 4,
  parameter int unsigned TYW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [TXW-1:0] rd_tx,
  input  logic [TYW-1:0] rd_ty,
  output hz_depth_t      rd_z,
  input  logic           up_en,
  input  logic [TXW-1:0] up_tx,
  input  logic [TYW-1:0] up_ty,
  input  hz_depth_t      up_z,
  output logic           wr_evt
);
  localparam int unsigned IW = TXW + TYW;
  localparam int unsigned NT = 1 << IW;

  hz_depth_t       ent [NT];
  logic [IW-1:0]   rd_idx, up_idx;

  assign rd_idx = {rd_ty, rd_tx};
  assign up_idx = {up_ty, up_tx};
  assign rd_z   = ent[rd_idx];
  assign wr_evt = up_en && !clr && hz_tighter(up_z, ent[up_idx]);

  for (genvar t = 0; t < NT; t++) begin : g_tile
    always_ff @(posedge clk) begin
      if (!rst_n || clr)
        ent[t] <= HZ_FAR;
      else if (wr_evt && (up_idx == IW'(t)))
        ent[t] <= up_z;
    end
  end
endmodule

// File: rtl/hz_out_stage.sv
module hz_out_stage #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic          take,
  output logic          ov,
  input  logic          ordy,
  output logic [DW-1:0] dout
);
  assign take = !ov || ordy;

  always_ff @(posedge clk) begin
    if (!rst_n)
      ov <= 1'b0;
    else if (take)
      ov <= load;
  end

  always_ff @(posedge clk) begin
    if (take && load)
      dout <= din;
  end
endmodule

// File: rtl/hz_early_cull.sv
module hz_early_cull
  import hz_pkg::*;
#(
  parameter int unsigned SCR_W     = 128,
  parameter int unsigned SCR_H     = 128,
  parameter int unsigned TILE_LOG2 = 3,
  localparam int unsigned XW  = $clog2(SCR_W),
  localparam int unsigned YW  = $clog2(SCR_H),
  localparam int unsigned TXW = XW - TILE_LOG2,
  localparam int unsigned TYW = YW - TILE_LOG2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [XW-1:0]   in_x,
  input  logic [YW-1:0]   in_y,
  input  logic [15:0]     in_z,
  input  logic            in_zmod,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XW-1:0]   out_x,
  output logic [YW-1:0]   out_y,
  output logic [15:0]     out_z,
  output logic            out_zmod,
  input  logic            upd_valid,
  input  logic            upd_full,
  input  logic [TXW-1:0]  upd_tx,
  input  logic [TYW-1:0]  upd_ty,
  input  logic [15:0]     upd_zmax
);
  localparam int unsigned DW = XW + YW + HZ_ZW + 1;

  // named internal events for the checker
  hz_depth_t       rd_z;
  logic            kill_w;
  logic            acc_w;
  logic            tile_wr_w;
  logic [DW-1:0]   pay_in, pay_out;

  hz_tile_store #(.TXW(TXW), .TYW(TYW)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clear),
    .rd_tx  (in_x[XW-1:TILE_LOG2]),
    .rd_ty  (in_y[YW-1:TILE_LOG2]),
    .rd_z   (rd_z),
    .up_en  (upd_valid && upd_full),
    .up_tx  (upd_tx),
    .up_ty  (upd_ty),
    .up_z   (upd_zmax),
    .wr_evt (tile_wr_w)
  );

  assign kill_w = in_valid && hz_is_hidden(in_z, rd_z, in_zmod);
  assign acc_w  = in_valid && in_ready;
  assign pay_in = {in_x, in_y, in_z, in_zmod};

  hz_out_stage #(.DW(DW)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (in_valid && !kill_w),
    .din   (pay_in),
    .take  (in_ready),
    .ov    (out_valid),
    .ordy  (out_ready),
    .dout  (pay_out)
  );

  assign {out_x, out_y, out_z, out_zmod} = pay_out;
endmodule

// File: rtl/hz_cull_chk.sv
module hz_cull_chk #(
  parameter int unsigned XW = 7,
  parameter int unsigned YW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clear,
  input logic          in_ready,
  input logic          in_zmod,
  input logic [15:0]   in_z,
  input logic          out_valid,
  input logic          out_ready,
  input logic [XW-1:0] out_x,
  input logic [YW-1:0] out_y,
  input logic [15:0]   out_z,
  input logic          out_zmod,
  input logic          acc_w,
  input logic          kill_w,
  input logic [15:0]   rd_z
);
  // R10
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_x) && $stable(out_y) && $stable(out_z));

  // R10
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R3
  kill_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_w && kill_w |=> !out_valid);

  // R5
  zmod_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_w && in_zmod |=> out_valid && out_zmod);

  // R4
  near_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_w && (in_z < rd_z) |=> out_valid && (out_z == $past(in_z)));

  // R9
  clear_far_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (rd_z == 16'hFFFF));
endmodule

bind hz_early_cull hz_cull_chk #(.XW(XW), .YW(YW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clear     (clear),
  .in_ready  (in_ready),
  .in_zmod   (in_zmod),
  .in_z      (in_z),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_x     (out_x),
  .out_y     (out_y),
  .out_z     (out_z),
  .out_zmod  (out_zmod),
  .acc_w     (acc_w),
  .kill_w    (kill_w),
  .rd_z      (rd_z)
);

// File: tb/tb_hz_early_cull.sv
`timescale 1ns/1ps
module tb_hz_early_cull;
  localparam int XW = 7, YW = 7, TXW = 4, TYW = 4;

  logic clk = 0, rst_n = 0, clear = 0;
  logic in_valid = 0, in_zmod = 0, out_ready = 1;
  logic [XW-1:0] in_x = '0;
  logic [YW-1:0] in_y = '0;
  logic [15:0] in_z = '0;
  logic upd_valid = 0, upd_full = 0;
  logic [TXW-1:0] upd_tx = '0;
  logic [TYW-1:0] upd_ty = '0;
  logic [15:0] upd_zmax = '0;
  logic in_ready, out_valid, out_zmod;
  logic [XW-1:0] out_x;
  logic [YW-1:0] out_y;
  logic [15:0] out_z;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  hz_early_cull dut (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .in_valid(in_valid), .in_ready(in_ready), .in_x(in_x), .in_y(in_y),
    .in_z(in_z), .in_zmod(in_zmod),
    .out_valid(out_valid), .out_ready(out_ready), .out_x(out_x), .out_y(out_y),
    .out_z(out_z), .out_zmod(out_zmod),
    .upd_valid(upd_valid), .upd_full(upd_full), .upd_tx(upd_tx),
    .upd_ty(upd_ty), .upd_zmax(upd_zmax)
  );

  typedef struct packed {
    logic [6:0]  x;
    logic [6:0]  y;
    logic [15:0] z;
    logic        zmod;
    logic        pass;
  } vec_t;

  // preceded by: tile(1,0)=4000, tile(2,3)=1000, others far
  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{7'd3,  7'd3,  16'h8000, 1'b0, 1'b1},  // R2 far tile
    '{7'd3,  7'd3,  16'hFFFF, 1'b0, 1'b0},  // R3 equal to far
    '{7'd9,  7'd2,  16'h4000, 1'b0, 1'b0},  // R3 equal
    '{7'd15, 7'd7,  16'h3FFF, 1'b0, 1'b1},  // R4 just nearer
    '{7'd8,  7'd0,  16'h9000, 1'b0, 1'b0},  // R3 farther
    '{7'd8,  7'd0,  16'h9000, 1'b1, 1'b1},  // R5 flag set
    '{7'd7,  7'd7,  16'h9000, 1'b0, 1'b1},  // R6 left neighbour
    '{7'd16, 7'd24, 16'h1000, 1'b0, 1'b0},  // R6 tile(2,3)
    '{7'd23, 7'd31, 16'h0FFF, 1'b0, 1'b1},  // R4 tile(2,3)
    '{7'd16, 7'd32, 16'h2000, 1'b0, 1'b1}   // R6 tile(2,4) far
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // one fragment, out_ready high; check forwarded or dropped
  task automatic frag(input int x, input int y, input int z, input logic zm,
                      input logic pass, input string req);
    @(negedge clk);
    in_valid = 1; in_x = XW'(x); in_y = YW'(y); in_z = 16'(z); in_zmod = zm;
    chk(in_ready, req, in_ready, 1);
    @(negedge clk);
    in_valid = 0;
    chk(out_valid == pass, req, out_valid, pass);
    if (pass && out_valid)
      chk(out_x == XW'(x) && out_y == YW'(y) && out_z == 16'(z) && out_zmod == zm,
          req, out_z, z);
  endtask

  task automatic upd(input int tx, input int ty, input int zm, input logic full);
    @(negedge clk);
    upd_valid = 1; upd_full = full; upd_tx = TXW'(tx); upd_ty = TYW'(ty);
    upd_zmax = 16'(zm);
    @(negedge clk);
    upd_valid = 0; upd_full = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    chk(!out_valid, "R1", out_valid, 0);
    chk(in_ready, "R1", in_ready, 1);
    frag(100, 90, 16'hFFFE, 0, 1, "R1");

    upd(1, 0, 16'h4000, 1);
    upd(2, 3, 16'h1000, 1);
    for (int i = 0; i < NV; i++)
      frag(VEC[i].x, VEC[i].y, VEC[i].z, VEC[i].zmod, VEC[i].pass, "R2-table");

    // R7 partial coverage ignored
    upd(5, 5, 16'h0100, 0);
    frag(40, 40, 16'h2000, 0, 1, "R7");

    // R8 farther report ignored
    upd(1, 0, 16'h6000, 1);
    frag(10, 1, 16'h5000, 0, 0, "R8");

    // R11 nearer report applies on the next edge
    upd(1, 0, 16'h2000, 1);
    frag(10, 1, 16'h3000, 0, 0, "R11");

    // R9 clear restores far plane
    @(negedge clk) clear = 1;
    @(negedge clk) clear = 0;
    frag(10, 1, 16'h5000, 0, 1, "R9");
    // R9 clear wins over a same-cycle update
    @(negedge clk);
    clear = 1; upd_valid = 1; upd_full = 1; upd_tx = 1; upd_ty = 0; upd_zmax = 16'h0010;
    @(negedge clk);
    clear = 0; upd_valid = 0; upd_full = 0;
    frag(10, 1, 16'h8000, 0, 1, "R9");

    // R10 backpressure
    @(negedge clk);
    out_ready = 0;
    in_valid = 1; in_x = 7'd50; in_y = 7'd60; in_z = 16'h0AAA; in_zmod = 0;
    @(negedge clk);
    in_x = 7'd51; in_y = 7'd61; in_z = 16'h0BBB;
    chk(out_valid && out_z == 16'h0AAA, "R10", out_z, 16'h0AAA);
    chk(!in_ready, "R10", in_ready, 0);
    repeat (2) @(negedge clk);
    chk(out_valid && out_z == 16'h0AAA && out_x == 7'd50, "R10", out_z, 16'h0AAA);
    chk(!in_ready, "R10", in_ready, 0);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk(out_valid && out_z == 16'h0BBB && out_y == 7'd61, "R10", out_z, 16'h0BBB);
    @(negedge clk);
    chk(!out_valid, "R10", out_valid, 0);

    summary();
    $finish;
  end
endmodule